// File: doc/BRIEF.md
# Real-Time Clock Event Flag and Interrupt Controller

This block produces the event flags and the interrupt request of a real-time clock. A once-per-second strobe starts an update window. The block raises an update-in-progress status bit at that point. After a fixed number of clock cycles the window ends in the update cycle. At that edge the block sets the update-ended flag and compares the current hours, minutes and seconds with the three alarm bytes. A periodic tick from an external rate selector sets a third flag.

Each flag is paired with an enable bit from the control byte. A set flag with its enable set raises a summary flag, and that summary flag drives the active-low open-drain interrupt pin. Reading the status byte clears every flag at once. The block also holds a user-visible copy of the time bytes, which it refreshes at the end of each update unless transfers are inhibited.

Time counting, format conversion and bus decoding are done elsewhere. The time and alarm bytes arrive here already formatted.

Top module: `rtc_evt_irq`

## Requirements
- R1: Reset clears every status flag, the user time copy and the update-in-progress bit. It also releases the interrupt, so `intDriveLow` is 0.
- R2: `uipFlag` is 1 for exactly `LEAD_CYC` cycles, starting the cycle after `secPulse` is sampled. It is 0 in every cycle where `ctrlByte[7]` (transfer inhibit) is 1.
- R3: At the end of each update window, which is `LEAD_CYC` edges after the pulse edge, the update-ended flag at `statusByte[4]` becomes 1.
- R4: At the end of an update window, the alarm flag at `statusByte[5]` becomes 1 when every alarm byte either matches its time byte or is don't-care. An alarm byte is don't-care when its two most significant bits are both 1. A byte with only bit 7 set is not don't-care.
- R5: A `periodicTick` pulse sets the periodic flag at `statusByte[6]`.
- R6: The summary flag at `statusByte[7]` and `intDriveLow` both become 1 when any of these pairs is set: periodic flag with `ctrlByte[6]`, alarm flag with `ctrlByte[5]`, or update-ended flag with `ctrlByte[4]`. The update-ended pair counts only while `ctrlByte[7]` is 0. Once set, the summary flag stays set until a read.
- R7: A `statusRd` cycle clears bits 7..4 of `statusByte` and releases `intDriveLow`, both taking effect after that edge.
- R8: A flag that is set in the same cycle as a status read stays set after that read. The summary flag is recomputed from the surviving flags.
- R9: `hourUser`, `minUser` and `secUser` take the current time bytes at the end of an update window only when `ctrlByte[7]` is 0. Otherwise they hold their value.
- R10: `statusByte[2]` reflects `osc32En`, and bits 3, 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secPulse | input | 1 | One-cycle strobe that opens an update window |
| periodicTick | input | 1 | One-cycle periodic event from the rate selector |
| hourNow | input | TIME_W | Current hours byte |
| minNow | input | TIME_W | Current minutes byte |
| secNow | input | TIME_W | Current seconds byte |
| hourAlm | input | TIME_W | Hours alarm byte |
| minAlm | input | TIME_W | Minutes alarm byte |
| secAlm | input | TIME_W | Seconds alarm byte |
| ctrlByte | input | 8 | [7] inhibit, [6] periodic en, [5] alarm en, [4] update en; rest unused here |
| osc32En | input | 1 | Fast-clock output enable, reported in status bit 2 |
| statusRd | input | 1 | Status read strobe; clears flags at the edge |
| statusByte | output | 8 | [7] summary, [6] periodic, [5] alarm, [4] update-ended, [2] osc32En |
| intDriveLow | output | 1 | 1 pulls the open-drain interrupt pin low |
| uipFlag | output | 1 | Update in progress |
| hourUser | output | TIME_W | User copy of hours |
| minUser | output | TIME_W | User copy of minutes |
| secUser | output | TIME_W | User copy of seconds |

## Verification
The bench targets the don't-care code. It tries an hours alarm byte with only its top bit set; a decoder that looked at one bit would treat it as don't-care and raise a false alarm. It also runs an update with the update interrupt enabled while transfers are inhibited. A design that ignored the inhibit there would pull the interrupt low, keep the update-in-progress bit high, or refresh the frozen user time copy. A periodic tick that coincides with a status read checks that the new flag and its summary survive the clear; a plain read-clear priority would lose that event.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

  // Strobes passed from the control half to the datapath half
  typedef struct packed {
    logic updEnd;   // last cycle of the update window
    logic rdClr;    // status byte being read this cycle
    logic xferEn;   // user copy may be refreshed
    logic uip;      // update in progress, visible value
  } ctlStrobe_t;

  // Status byte bit positions
  localparam int ST_SUM  = 7;
  localparam int ST_PER  = 6;
  localparam int ST_ALM  = 5;
  localparam int ST_UPD  = 4;
  localparam int ST_OSC  = 2;

  // Control byte bit positions
  localparam int CB_INH  = 7;
  localparam int CB_PIE  = 6;
  localparam int CB_AIE  = 5;
  localparam int CB_UIE  = 4;

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int TIME_W     = 8,
  parameter int NUM_FIELDS = 3
) (
  input  logic [NUM_FIELDS-1:0][TIME_W-1:0] timeVec,
  input  logic [NUM_FIELDS-1:0][TIME_W-1:0] almVec,
  output logic                              hit
);

  logic [NUM_FIELDS-1:0] dontCare;
  logic [NUM_FIELDS-1:0] fieldOk;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    // both top bits set marks the byte as excluded from the compare
    assign dontCare[f] = &almVec[f][TIME_W-1 -: 2];
    assign fieldOk[f]  = dontCare[f] | (almVec[f] == timeVec[f]);
  end

  assign hit = &fieldOk;

endmodule

// File: rtl/rtc_evt_ctrl.sv
module rtc_evt_ctrl
  import rtc_evt_pkg::*;
#(
  parameter int LEAD_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secPulse,
  input  logic       statusRd,
  input  logic       xferInhibit,
  output ctlStrobe_t ctl
);

  localparam int             CNT_W = $clog2(LEAD_CYC + 1);
  localparam [CNT_W-1:0]     LAST  = CNT_W'(LEAD_CYC - 1);

  logic             busy;
  logic [CNT_W-1:0] leadCnt;
  logic             endNow;

  assign endNow = busy && (leadCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      leadCnt <= '0;
    end else if (!busy) begin
      if (secPulse) begin
        busy    <= 1'b1;
        leadCnt <= '0;
      end
    end else if (endNow) begin
      busy    <= 1'b0;
      leadCnt <= '0;
    end else begin
      leadCnt <= leadCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.updEnd = endNow;
    ctl.rdClr  = statusRd;
    ctl.xferEn = ~xferInhibit;
    ctl.uip    = busy & ~xferInhibit;
  end

endmodule

// File: rtl/rtc_evt_dp.sv
module rtc_evt_dp
  import rtc_evt_pkg::*;
#(
  parameter int TIME_W     = 8,
  parameter int NUM_FIELDS = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctlStrobe_t                        ctl,
  input  logic                              periodicTick,
  input  logic                              almHit,
  input  logic [NUM_FIELDS-1:0][TIME_W-1:0] timeVec,
  input  logic                              perEn,
  input  logic                              almEn,
  input  logic                              updEn,
  input  logic                              osc32En,
  output logic [7:0]                        statusByte,
  output logic                              intDriveLow,
  output logic [NUM_FIELDS-1:0][TIME_W-1:0] userVec
);

  logic perQ, almQ, updQ, sumQ;
  logic perN, almN, updN, sumN;
  logic reqN;

  // Read clears first; an event in the same cycle then sets again
  always_comb begin
    perN = ctl.rdClr ? 1'b0 : perQ;
    almN = ctl.rdClr ? 1'b0 : almQ;
    updN = ctl.rdClr ? 1'b0 : updQ;
    if (periodicTick)           perN = 1'b1;
    if (ctl.updEnd && almHit)   almN = 1'b1;
    if (ctl.updEnd)             updN = 1'b1;
    reqN = (perN & perEn) | (almN & almEn) | (updN & updEn & ctl.xferEn);
    sumN = (ctl.rdClr ? 1'b0 : sumQ) | reqN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perQ <= 1'b0;
      almQ <= 1'b0;
      updQ <= 1'b0;
      sumQ <= 1'b0;
    end else begin
      perQ <= perN;
      almQ <= almN;
      updQ <= updN;
      sumQ <= sumN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      userVec <= '0;
    end else if (ctl.updEnd && ctl.xferEn) begin
      userVec <= timeVec;
    end
  end

  always_comb begin
    statusByte         = 8'h00;
    statusByte[ST_SUM] = sumQ;
    statusByte[ST_PER] = perQ;
    statusByte[ST_ALM] = almQ;
    statusByte[ST_UPD] = updQ;
    statusByte[ST_OSC] = osc32En;
  end

  assign intDriveLow = sumQ;

endmodule

// File: rtl/rtc_evt_irq.sv
module rtc_evt_irq
  import rtc_evt_pkg::*;
#(
  parameter int LEAD_CYC = 4,
  parameter int TIME_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secPulse,
  input  logic              periodicTick,
  input  logic [TIME_W-1:0] hourNow,
  input  logic [TIME_W-1:0] minNow,
  input  logic [TIME_W-1:0] secNow,
  input  logic [TIME_W-1:0] hourAlm,
  input  logic [TIME_W-1:0] minAlm,
  input  logic [TIME_W-1:0] secAlm,
  input  logic [7:0]        ctrlByte,
  input  logic              osc32En,
  input  logic              statusRd,
  output logic [7:0]        statusByte,
  output logic              intDriveLow,
  output logic              uipFlag,
  output logic [TIME_W-1:0] hourUser,
  output logic [TIME_W-1:0] minUser,
  output logic [TIME_W-1:0] secUser
);

  localparam int NUM_FIELDS = 3;

  ctlStrobe_t                        ctlBus;
  logic [NUM_FIELDS-1:0][TIME_W-1:0] timeVec;
  logic [NUM_FIELDS-1:0][TIME_W-1:0] almVec;
  logic [NUM_FIELDS-1:0][TIME_W-1:0] userVec;
  logic                              almHit;

  assign timeVec = {hourNow, minNow, secNow};
  assign almVec  = {hourAlm, minAlm, secAlm};

  rtc_evt_ctrl #(.LEAD_CYC(LEAD_CYC)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .secPulse    (secPulse),
    .statusRd    (statusRd),
    .xferInhibit (ctrlByte[CB_INH]),
    .ctl         (ctlBus)
  );

  rtc_alarm_cmp #(.TIME_W(TIME_W), .NUM_FIELDS(NUM_FIELDS)) cmp_i (
    .timeVec (timeVec),
    .almVec  (almVec),
    .hit     (almHit)
  );

  rtc_evt_dp #(.TIME_W(TIME_W), .NUM_FIELDS(NUM_FIELDS)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctlBus),
    .periodicTick (periodicTick),
    .almHit       (almHit),
    .timeVec      (timeVec),
    .perEn        (ctrlByte[CB_PIE]),
    .almEn        (ctrlByte[CB_AIE]),
    .updEn        (ctrlByte[CB_UIE]),
    .osc32En      (osc32En),
    .statusByte   (statusByte),
    .intDriveLow  (intDriveLow),
    .userVec      (userVec)
  );

  assign uipFlag  = ctlBus.uip;
  assign hourUser = userVec[2];
  assign minUser  = userVec[1];
  assign secUser  = userVec[0];

endmodule

// File: rtl/rtc_evt_irq_chk.sv
module rtc_evt_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       periodicTick,
  input logic       statusRd,
  input logic       updEnd,
  input logic [7:0] ctrlByte,
  input logic [7:0] statusByte,
  input logic       intDriveLow,
  input logic       uipFlag
);

  // R2: inhibit forces the in-progress bit low
  a_r2_uip_inhibit: assert property (@(posedge clk) disable iff (!rstN)
    ctrlByte[7] |-> !uipFlag);

  // R3: end of window sets the update-ended flag
  a_r3_upd_flag: assert property (@(posedge clk) disable iff (!rstN)
    updEnd |=> statusByte[4]);

  // R5: periodic tick sets its flag
  a_r5_per_flag: assert property (@(posedge clk) disable iff (!rstN)
    periodicTick |=> statusByte[6]);

  // R6: enabled periodic flag pulls the pin low
  a_r6_per_req: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6] && ctrlByte[6] && !statusRd) |=> intDriveLow);

  // R7: a read with no new event clears flags and pin
  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !periodicTick && !updEnd) |=> (statusByte[7:4] == 4'h0 && !intDriveLow));

  // R8: event coinciding with a read survives it
  a_r8_keep_new: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && periodicTick) |=> statusByte[6]);

endmodule

bind rtc_evt_irq rtc_evt_irq_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .periodicTick (periodicTick),
  .statusRd     (statusRd),
  .updEnd       (ctlBus.updEnd),
  .ctrlByte     (ctrlByte),
  .statusByte   (statusByte),
  .intDriveLow  (intDriveLow),
  .uipFlag      (uipFlag)
);

// File: tb/rtc_evt_irq_tb_top.sv
`timescale 1ns/1ps
module rtc_evt_irq_tb_top;

  localparam int LEAD = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secPulse = 1'b0;
  logic       periodicTick = 1'b0;
  logic [7:0] hourNow = 8'h00, minNow = 8'h00, secNow = 8'h00;
  logic [7:0] hourAlm = 8'h01, minAlm = 8'h02, secAlm = 8'h03;
  logic [7:0] ctrlByte = 8'h00;
  logic       osc32En = 1'b0;
  logic       statusRd = 1'b0;
  logic [7:0] statusByte;
  logic       intDriveLow, uipFlag;
  logic [7:0] hourUser, minUser, secUser;

  int vecCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rtc_evt_irq #(.LEAD_CYC(LEAD), .TIME_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .secPulse(secPulse), .periodicTick(periodicTick),
    .hourNow(hourNow), .minNow(minNow), .secNow(secNow),
    .hourAlm(hourAlm), .minAlm(minAlm), .secAlm(secAlm),
    .ctrlByte(ctrlByte), .osc32En(osc32En), .statusRd(statusRd),
    .statusByte(statusByte), .intDriveLow(intDriveLow), .uipFlag(uipFlag),
    .hourUser(hourUser), .minUser(minUser), .secUser(secUser)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Opens an update window and checks the in-progress bit each cycle
  task automatic runUpdate(input logic expUip);
    @(negedge clk) secPulse = 1'b1;
    @(negedge clk) secPulse = 1'b0;
    for (int i = 0; i < LEAD; i++) begin
      chk("R2 uip in window", uipFlag, expUip);
      if (i < LEAD - 1) @(negedge clk);
    end
    @(negedge clk);
    chk("R2 uip after window", uipFlag, 1'b0);
  endtask

  task automatic readStatus(output logic [7:0] val);
    @(negedge clk) statusRd = 1'b1;
    val = statusByte;
    @(negedge clk) statusRd = 1'b0;
  endtask

  task automatic clearAndCheck(input string req);
    logic [7:0] v;
    readStatus(v);
    chk({req, " flags after read"}, statusByte[7:4], 4'h0);
    chk({req, " pin after read"}, intDriveLow, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 status", statusByte, 8'h00);
    chk("R1 pin", intDriveLow, 1'b0);
    chk("R1 uip", uipFlag, 1'b0);
    chk("R1 user", {hourUser, minUser, secUser}, 24'h0);
  endtask

  task automatic t_layout;
    osc32En = 1'b1;
    @(negedge clk);
    chk("R10 osc bit", statusByte, 8'h04);
    osc32En = 1'b0;
    @(negedge clk);
    chk("R10 osc off", statusByte, 8'h00);
  endtask

  task automatic t_plainUpdate;
    hourNow = 8'h12; minNow = 8'h30; secNow = 8'h45;
    ctrlByte = 8'h00;
    runUpdate(1'b1);
    chk("R3 update flag only", statusByte, 8'h10);
    chk("R6 no enable no pin", intDriveLow, 1'b0);
    chk("R9 user copy", {hourUser, minUser, secUser}, 24'h123045);
    clearAndCheck("R7");
  endtask

  task automatic t_updIrq;
    ctrlByte = 8'h10;
    runUpdate(1'b1);
    chk("R6 update irq status", statusByte, 8'h90);
    chk("R6 update irq pin", intDriveLow, 1'b1);
    clearAndCheck("R7");
  endtask

  task automatic t_inhibit;
    ctrlByte = 8'h90;
    hourNow = 8'h13; minNow = 8'h31; secNow = 8'h46;
    runUpdate(1'b0);
    chk("R6 inhibited update", statusByte, 8'h10);
    chk("R6 inhibited pin", intDriveLow, 1'b0);
    chk("R9 frozen copy", {hourUser, minUser, secUser}, 24'h123045);
    clearAndCheck("R7");
    ctrlByte = 8'h00;
  endtask

  task automatic t_alarms;
    hourNow = 8'h07; minNow = 8'h15; secNow = 8'h20;
    hourAlm = 8'h07; minAlm = 8'h15; secAlm = 8'h20;
    runUpdate(1'b1);
    chk("R4 exact match", statusByte, 8'h30);
    clearAndCheck("R7");
    ctrlByte = 8'h20;
    runUpdate(1'b1);
    chk("R6 alarm irq", statusByte, 8'hB0);
    chk("R6 alarm pin", intDriveLow, 1'b1);
    clearAndCheck("R7");
    ctrlByte = 8'h00;
    secAlm = 8'h21;
    runUpdate(1'b1);
    chk("R4 seconds mismatch", statusByte, 8'h10);
    clearAndCheck("R7");
    secAlm = 8'h20; hourAlm = 8'hC0; hourNow = 8'h09;
    runUpdate(1'b1);
    chk("R4 hours dont-care", statusByte, 8'h30);
    clearAndCheck("R7");
    hourAlm = 8'hFF; minAlm = 8'hFF; secAlm = 8'hFF;
    runUpdate(1'b1);
    chk("R4 all dont-care", statusByte, 8'h30);
    clearAndCheck("R7");
    hourAlm = 8'h80; minAlm = 8'h15; secAlm = 8'h20;
    runUpdate(1'b1);
    chk("R4 single top bit not dont-care", statusByte, 8'h10);
    clearAndCheck("R7");
  endtask

  task automatic t_periodic;
    ctrlByte = 8'h00;
    @(negedge clk) periodicTick = 1'b1;
    @(negedge clk) periodicTick = 1'b0;
    chk("R5 periodic flag", statusByte, 8'h40);
    chk("R6 periodic no enable", intDriveLow, 1'b0);
    clearAndCheck("R7");
    ctrlByte = 8'h40;
    @(negedge clk) periodicTick = 1'b1;
    @(negedge clk) periodicTick = 1'b0;
    chk("R6 periodic irq", statusByte, 8'hC0);
    chk("R6 periodic pin", intDriveLow, 1'b1);
    clearAndCheck("R7");
  endtask

  task automatic t_sameCycle;
    ctrlByte = 8'h40;
    runUpdate(1'b1);
    chk("R3 preset flag", statusByte, 8'h10);
    @(negedge clk) begin periodicTick = 1'b1; statusRd = 1'b1; end
    @(negedge clk) begin periodicTick = 1'b0; statusRd = 1'b0; end
    chk("R8 new flag kept", statusByte, 8'hC0);
    chk("R8 pin kept", intDriveLow, 1'b1);
    clearAndCheck("R7");
  endtask

  task automatic t_midReset;
    ctrlByte = 8'h50;
    runUpdate(1'b1);
    @(negedge clk) secPulse = 1'b1;
    @(negedge clk) begin secPulse = 1'b0; rstN = 1'b0; end
    @(negedge clk) rstN = 1'b1;
    chk("R1 reset flags", statusByte, 8'h00);
    chk("R1 reset pin", intDriveLow, 1'b0);
    chk("R1 reset uip", uipFlag, 1'b0);
    chk("R1 reset user", {hourUser, minUser, secUser}, 24'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_plainUpdate();
    t_updIrq();
    t_inhibit();
    t_alarms();
    t_periodic();
    t_sameCycle();
    t_midReset();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vecCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

endmodule